// File: doc/BRIEF.md
# Express-Channel On/Off Threshold Controller

This block sits at one router input port and watches how many slots of the shared flit buffer pool are still free. Upstream routers reach the port over express channels that span 1 to `MAX_LEN` hops. A sender k hops away must learn to pause early enough that every flit already on its way still finds a slot. The block therefore keeps one threshold and one on/off flag per channel length. The threshold for length k is 3k − 1: k cycles for the token to travel back, plus 2k − 1 flits that may already be in flight at two cycles per bypassed router.

Each cycle the block takes a one-slot allocate strobe and a one-slot release strobe and updates its free count. It then compares the new count with every threshold. When a length's flag changes, the block emits a one-cycle stop or start token for that length. The token transport itself is handled elsewhere. A configuration whose pool is not deeper than the largest threshold is rejected at elaboration.

Top module: `evc_onoff_thresh`

## Requirements
- R1: During reset and in the first cycle after it, the pool is fully free (`POOL_DEPTH` slots), every bit of `lenOn` is 1, and no stop or start pulse is raised.
- R2: Bit k−1 of `lenOn` is the on/off flag for express length k (k = 1 to `MAX_LEN`), and its threshold is 3k − 1 free slots.
- R3: When the free count falls below the threshold of a length that is on, that length's `lenOn` bit clears and its `stopPulse` bit is high for exactly one cycle. Both change at the clock edge that samples the allocate strobe.
- R4: When the free count rises above the threshold of a length that is off, that length's `lenOn` bit sets and its `startPulse` bit is high for exactly one cycle. Both change at the clock edge that samples the release strobe.
- R5: While a flag holds its value, no pulse is raised for that length. A free count exactly equal to the threshold leaves the flag unchanged in either direction.
- R6: An allocate and a release in the same cycle cancel: the free count, all flags and all pulses behave as if neither strobe was present.
- R7: An allocate with no free slot is ignored, and a release with the pool already full is ignored. The free count stays within 0 to `POOL_DEPTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | One buffer slot is taken this cycle |
| releaseReq | input | 1 | One buffer slot is returned this cycle |
| lenOn | output | MAX_LEN | Per-length on/off flag, bit k−1 for length k |
| stopPulse | output | MAX_LEN | One-cycle stop token, per length |
| startPulse | output | MAX_LEN | One-cycle start token, per length |

## Verification
The free count is not visible at the ports. An error in it shows up only when it moves a threshold crossing, because the flags and tokens then flip one or more cycles early or late relative to a counted strobe sequence. The bench therefore keeps its own count and compares every flag and pulse on every cycle. A lost or doubled step is caught at the next crossing of any of the `MAX_LEN` thresholds, and with thresholds three slots apart that crossing is at most a few strobes away. Directed walks across each boundary, held at the exact threshold and pushed past empty and full, pin down the hysteresis and the clamping.

// File: rtl/evc_thr_pkg.sv
`timescale 1ns/1ps
package evc_thr_pkg;
  // Net step applied to the free-slot counter in one cycle
  typedef struct packed {
    logic inc;
    logic dec;
  } poolStep_t;

  // Free slots that must remain for a sender k hops away:
  // token return of k cycles plus 2k-1 flits possibly in flight
  function automatic int thrFor(input int k);
    return 3 * k - 1;
  endfunction
endpackage

// File: rtl/evc_thr_ctrl.sv
`timescale 1ns/1ps
module evc_thr_ctrl
  import evc_thr_pkg::*;
(
  input  logic      allocReq,
  input  logic      releaseReq,
  input  logic      poolEmpty,
  input  logic      poolFull,
  output poolStep_t step
);
  // Simultaneous strobes cancel (R6); clamp at empty and full (R7)
  always_comb begin
    step.inc = releaseReq && !allocReq && !poolFull;
    step.dec = allocReq && !releaseReq && !poolEmpty;
  end
endmodule

// File: rtl/evc_thr_datapath.sv
`timescale 1ns/1ps
module evc_thr_datapath
  import evc_thr_pkg::*;
#(
  parameter int MAX_LEN    = 6,
  parameter int POOL_DEPTH = 20,
  localparam int CW        = $clog2(POOL_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  poolStep_t          step,
  output logic               poolEmpty,
  output logic               poolFull,
  output logic [CW-1:0]      freeCnt,
  output logic [MAX_LEN-1:0] lenOn,
  output logic [MAX_LEN-1:0] stopPulse,
  output logic [MAX_LEN-1:0] startPulse
);
  localparam logic [CW-1:0] FULL_V = CW'(POOL_DEPTH);

  logic [CW-1:0] nextFree;

  always_comb begin
    nextFree = freeCnt;
    if (step.inc)      nextFree = freeCnt + CW'(1);
    else if (step.dec) nextFree = freeCnt - CW'(1);
  end

  assign poolEmpty = (freeCnt == '0);
  assign poolFull  = (freeCnt == FULL_V);

  always_ff @(posedge clk) begin
    if (!rstN) freeCnt <= FULL_V;
    else       freeCnt <= nextFree;
  end

  // One comparator pair and flag per express length (R2..R5)
  for (genvar g = 0; g < MAX_LEN; g++) begin : g_len
    localparam logic [CW-1:0] THR_V = CW'(thrFor(g + 1));
    logic belowThr;
    logic aboveThr;
    logic goOff;
    logic goOn;

    assign belowThr = (nextFree < THR_V);
    assign aboveThr = (nextFree > THR_V);
    assign goOff    = lenOn[g] && belowThr;
    assign goOn     = !lenOn[g] && aboveThr;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lenOn[g]      <= 1'b1;
        stopPulse[g]  <= 1'b0;
        startPulse[g] <= 1'b0;
      end else begin
        stopPulse[g]  <= goOff;
        startPulse[g] <= goOn;
        if (goOff)     lenOn[g] <= 1'b0;
        else if (goOn) lenOn[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/evc_onoff_thresh.sv
`timescale 1ns/1ps
module evc_onoff_thresh
  import evc_thr_pkg::*;
#(
  parameter int MAX_LEN    = 6,
  parameter int POOL_DEPTH = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocReq,
  input  logic               releaseReq,
  output logic [MAX_LEN-1:0] lenOn,
  output logic [MAX_LEN-1:0] stopPulse,
  output logic [MAX_LEN-1:0] startPulse
);
  localparam int CW = $clog2(POOL_DEPTH + 1);

  // The pool must cover the largest threshold
  if (MAX_LEN < 1 || POOL_DEPTH <= thrFor(MAX_LEN)) begin : g_badCfg
    $error("evc_onoff_thresh: POOL_DEPTH must exceed 3*MAX_LEN-1");
  end

  poolStep_t     step;
  logic          poolEmpty;
  logic          poolFull;
  logic [CW-1:0] freeCnt;

  evc_thr_ctrl u_ctrl (
    .allocReq  (allocReq),
    .releaseReq(releaseReq),
    .poolEmpty (poolEmpty),
    .poolFull  (poolFull),
    .step      (step)
  );

  evc_thr_datapath #(
    .MAX_LEN   (MAX_LEN),
    .POOL_DEPTH(POOL_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .step      (step),
    .poolEmpty (poolEmpty),
    .poolFull  (poolFull),
    .freeCnt   (freeCnt),
    .lenOn     (lenOn),
    .stopPulse (stopPulse),
    .startPulse(startPulse)
  );
endmodule

// File: rtl/evc_onoff_thresh_chk.sv
`timescale 1ns/1ps
module evc_onoff_thresh_chk
  import evc_thr_pkg::*;
#(
  parameter int MAX_LEN    = 6,
  parameter int POOL_DEPTH = 20,
  localparam int CW        = $clog2(POOL_DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               allocReq,
  input logic               releaseReq,
  input logic [CW-1:0]      freeCnt,
  input logic [MAX_LEN-1:0] lenOn,
  input logic [MAX_LEN-1:0] stopPulse,
  input logic [MAX_LEN-1:0] startPulse
);
  localparam logic [CW-1:0] FULL_V = CW'(POOL_DEPTH);

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN) freeCnt <= FULL_V); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (freeCnt == '0 && allocReq && !releaseReq) |=> (freeCnt == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (freeCnt == FULL_V && releaseReq && !allocReq) |=> (freeCnt == FULL_V)); // R7
  AST_SIMUL_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && releaseReq) |=> $stable(freeCnt)); // R6

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_chk
    localparam logic [CW-1:0] THR_V = CW'(thrFor(g + 1));
    AST_OFF_BELOW: assert property (@(posedge clk) disable iff (!rstN)
      (freeCnt < THR_V) |-> !lenOn[g]); // R3
    AST_ON_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
      (freeCnt > THR_V) |-> lenOn[g]); // R4
    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
      ((stopPulse[g] || startPulse[g]) == (lenOn[g] != $past(lenOn[g])))); // R5
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      !(stopPulse[g] && startPulse[g])); // R5
  end
endmodule

bind evc_onoff_thresh evc_onoff_thresh_chk #(
  .MAX_LEN   (MAX_LEN),
  .POOL_DEPTH(POOL_DEPTH)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .allocReq  (allocReq),
  .releaseReq(releaseReq),
  .freeCnt   (freeCnt),
  .lenOn     (lenOn),
  .stopPulse (stopPulse),
  .startPulse(startPulse)
);

// File: tb/evc_onoff_thresh_tb.sv
`timescale 1ns/1ps
module evc_onoff_thresh_tb;
  localparam int L  = 6;
  localparam int D  = 20;
  localparam int WD = 200000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN;
  logic         allocReq;
  logic         releaseReq;
  logic [L-1:0] lenOn;
  logic [L-1:0] stopPulse;
  logic [L-1:0] startPulse;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  int           mFree;
  logic [L-1:0] mOn;
  logic [L-1:0] mStop;
  logic [L-1:0] mStart;

  evc_onoff_thresh #(.MAX_LEN(L), .POOL_DEPTH(D)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .allocReq  (allocReq),
    .releaseReq(releaseReq),
    .lenOn     (lenOn),
    .stopPulse (stopPulse),
    .startPulse(startPulse)
  );

  function automatic int thr(input int k);
    return 3 * k - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model from the requirements
  task automatic modelStep(input bit a, input bit r);
    if (a && !r && mFree > 0)      mFree--;
    else if (r && !a && mFree < D) mFree++;
    for (int k = 1; k <= L; k++) begin
      mStop[k-1]  = 1'b0;
      mStart[k-1] = 1'b0;
      if (mOn[k-1] && mFree < thr(k)) begin
        mOn[k-1] = 1'b0; mStop[k-1] = 1'b1;
      end else if (!mOn[k-1] && mFree > thr(k)) begin
        mOn[k-1] = 1'b1; mStart[k-1] = 1'b1;
      end
    end
  endtask

  task automatic compareAll();
    chk(lenOn == mOn, "R2", "lenOn", int'(lenOn), int'(mOn));
    chk(stopPulse == mStop, "R3", "stopPulse", int'(stopPulse), int'(mStop));
    chk(startPulse == mStart, "R4", "startPulse", int'(startPulse), int'(mStart));
  endtask

  task automatic step(input bit a, input bit r);
    @(negedge clk);
    allocReq   = a;
    releaseReq = r;
    @(posedge clk);
    modelStep(a, r);
    #5;
    compareAll();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(20 * WD);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; allocReq = 1'b0; releaseReq = 1'b0;
    mFree = D; mOn = '1; mStop = '0; mStart = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lenOn == '1, "R1", "lenOn in reset", int'(lenOn), int'({L{1'b1}}));
    chk((stopPulse | startPulse) == '0, "R1", "pulses in reset",
        int'(stopPulse | startPulse), 0);
    rstN = 1'b1;
    @(posedge clk); #5;
    chk(lenOn == '1, "R1", "lenOn after reset", int'(lenOn), int'({L{1'b1}}));

    // Drain the pool completely
    for (int i = 0; i < D; i++) step(1'b1, 1'b0);
    chk(lenOn == '0, "R3", "all off when empty", int'(lenOn), 0);
    // Allocate at empty is ignored (R7), then a cancelling pair (R6)
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk(startPulse[0] == 1'b0, "R5", "no start at free==thr(1)", int'(startPulse[0]), 0);
    step(1'b0, 1'b1);
    chk(startPulse[0] == 1'b1, "R4", "start len1 at free 3", int'(startPulse[0]), 1);
    step(1'b0, 1'b0);
    chk(startPulse[0] == 1'b0, "R4", "start pulse one cycle", int'(startPulse[0]), 0);

    // Hover around the length-3 threshold (8)
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    chk(lenOn[2] == 1'b1, "R4", "len3 on at free 9", int'(lenOn[2]), 1);
    step(1'b1, 1'b0);
    chk(lenOn[2] == 1'b1 && stopPulse[2] == 1'b0, "R5", "hold at free 8",
        int'(lenOn[2]), 1);
    step(1'b1, 1'b0);
    chk(stopPulse[2] == 1'b1, "R3", "stop len3 at free 7", int'(stopPulse[2]), 1);
    step(1'b0, 1'b1);
    chk(lenOn[2] == 1'b0 && startPulse[2] == 1'b0, "R5", "hold off at free 8",
        int'(lenOn[2]), 0);
    step(1'b1, 1'b1);
    chk(lenOn[2] == 1'b0, "R6", "pair cancels at threshold", int'(lenOn[2]), 0);
    step(1'b0, 1'b1);
    chk(startPulse[2] == 1'b1, "R4", "start len3 at free 9", int'(startPulse[2]), 1);

    // Fill, push past full (R7), then cross the length-6 threshold
    for (int i = 0; i < D; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    chk(lenOn[5] == 1'b1, "R7", "release at full ignored", int'(lenOn[5]), 1);
    step(1'b1, 1'b0);
    chk(stopPulse[5] == 1'b1, "R3", "stop len6 at free 16", int'(stopPulse[5]), 1);

    // Biased random phases sweeping the pool up and down
    for (int ph = 0; ph < 12; ph++) begin
      int pA = (ph % 2 == 0) ? 65 : 30;
      int pR = (ph % 2 == 0) ? 30 : 65;
      for (int i = 0; i < 250; i++)
        step(($urandom % 100) < pA, ($urandom % 100) < pR);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule